// File: doc/BRIEF.md
# Power-On Reset Stretcher

This block supervises a system reset line from a digital power-fail flag and a free-running timebase of its own. While the supply is below the trip point, the flag is high and the block pulls its reset output low at once, through a purely combinational path. When the flag clears, the reset keeps being pulled for a programmed stretch measured in timebase ticks. The stretch length is derived from the timebase frequency and a requested length in milliseconds. The requested length is clamped into a 40 to 200 ms window. The timebase belongs to the supervisor alone, so the stretch runs whether or not any clock oscillator elsewhere is enabled.

The reset output is modelled as an open-drain enable. A 1 means the pin is pulled low. A 0 means the pin is released. The pin is never driven high. Before it feeds the stretch counter, the power-fail flag passes through a two-flop synchronizer.

The same block picks the backup supply from two battery flags. It also raises a battery-low flag when neither battery is above its minimum.

Top module: `por_stretch_top`

## Requirements
- R1: Whenever `pwr_fail` is 1, `rst_pull_low` is 1 in the same cycle, combinationally, with no clock edge needed. On `rst_pull_low`, 1 means pull the reset pin low and 0 means release it.
- R2: While `rst_n` is 0, `rst_pull_low` is 1. Leaving reset counts the same as the power-fail flag having been sampled high at the last edge before release.
- R3: Let E be the last rising edge of `clk` at which `pwr_fail` was sampled 1. If `pwr_fail` then stays 0, `rst_pull_low` stays 1 up to the (TERM+2)-th rising edge after E and goes to 0 at that edge. The count covers two synchronizer edges plus TERM counting edges.
- R4: TERM = floor(TB_HZ × M / 1000), where M is STRETCH_MS clamped to the range 40..200, and TERM is at least 1. With defaults (TB_HZ=32768, STRETCH_MS=100), TERM is 3276. With STRETCH_MS=10, TERM is 1310.
- R5: If `pwr_fail` is sampled 1 at any edge during a stretch, the stretch restarts from zero and the R3 rule applies from that edge. A pulse that covers a single edge is enough.
- R6: `bat_sel` is 1 (battery 2) when `bat2_higher` is 1. Otherwise it is 0 (battery 1). It follows the input combinationally.
- R7: `bat_low` is 1 exactly when `bat1_ok` and `bat2_ok` are both 0. It follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated supervisor timebase |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor flops |
| pwr_fail | input | 1 | Asynchronous flag: supply below the trip point |
| bat1_ok | input | 1 | Battery 1 is above its minimum level |
| bat2_ok | input | 1 | Battery 2 is above its minimum level |
| bat2_higher | input | 1 | Comparator flag: battery 2 voltage exceeds battery 1 |
| rst_pull_low | output | 1 | Open-drain enable: 1 pulls reset low, 0 releases it |
| bat_sel | output | 1 | Selected backup source: 0 is battery 1, 1 is battery 2 |
| bat_low | output | 1 | Both batteries are below their minimum |

## Verification
The stretch counter can see a new power-fail sample on the same edge that would otherwise end the stretch at its terminal count. In that case the restart must win and the reset must stay pulled. The bench provokes this by placing single-cycle fail pulses at random points in each stretch. It also places directed pulses exactly at the edge where release is due. Each run is judged against a bench model that counts edges since the last high sample, and the pull output is checked at every falling edge.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic {
    BAT_ONE = 1'b0,
    BAT_TWO = 1'b1
  } bat_sel_e;

  localparam int unsigned MS_MIN = 40;
  localparam int unsigned MS_MAX = 200;

  // Clamp the requested stretch into the allowed window, convert to ticks.
  function automatic int unsigned stretch_ticks(input int unsigned hz,
                                                input int unsigned ms);
    longint unsigned m;
    longint unsigned t;
    m = (ms < MS_MIN) ? longint'(MS_MIN) : ((ms > MS_MAX) ? longint'(MS_MAX) : longint'(ms));
    t = (longint'(hz) * m) / 64'd1000;
    if (t == 64'd0) t = 64'd1;
    return int'(t);
  endfunction

  function automatic bat_sel_e pick_battery(input logic b2_higher);
    return b2_higher ? BAT_TWO : BAT_ONE;
  endfunction

  function automatic logic both_batteries_low(input logic ok1, input logic ok2);
    return !(ok1 || ok2);
  endfunction

endpackage

// File: rtl/por_fail_sync.sv
module por_fail_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_async,
  output logic fail_sync,
  output logic fail_pending
);

  logic stage1_q;
  logic stage2_q;

  // Both stages come out of reset reporting a failure.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b1;
      stage2_q <= 1'b1;
    end else begin
      stage1_q <= fail_async;
      stage2_q <= stage1_q;
    end
  end

  assign fail_sync    = stage2_q;
  assign fail_pending = stage1_q | stage2_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage2_q) |-> $past(fail_async, 2)) else $error("sync latency"); // R5

endmodule

// File: rtl/por_stretch_ctr.sv
module por_stretch_ctr #(
  parameter int unsigned TERM = 16,
  parameter int unsigned CW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fail_sync,
  output logic          stretching,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic          stretch_q;
  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretch_q <= 1'b1;
      cnt_q     <= '0;
    end else if (fail_sync) begin
      stretch_q <= 1'b1;
      cnt_q     <= '0;
    end else if (stretch_q) begin
      if (at_last) begin
        stretch_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign stretching = stretch_q;
  assign count      = cnt_q;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fail_sync |=> (stretch_q && cnt_q == '0)) else $error("no restart"); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_q |-> (cnt_q <= LAST)) else $error("count overflow"); // R3
  AST_RELEASE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stretch_q) |-> ($past(cnt_q) == LAST)) else $error("early release"); // R3
  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !stretch_q |-> (cnt_q == '0)) else $error("idle count"); // R4

endmodule

// File: rtl/por_batt_sel.sv
module por_batt_sel (
  input  logic bat1_ok,
  input  logic bat2_ok,
  input  logic bat2_higher,
  output logic bat_sel,
  output logic bat_low
);
  import por_pkg::*;

  bat_sel_e sel;

  always_comb begin
    sel     = pick_battery(bat2_higher);
    bat_sel = sel;
    bat_low = both_batteries_low(bat1_ok, bat2_ok);
  end

endmodule

// File: rtl/por_stretch_top.sv
module por_stretch_top #(
  parameter int unsigned TB_HZ      = 32768,
  parameter int unsigned STRETCH_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic bat1_ok,
  input  logic bat2_ok,
  input  logic bat2_higher,
  output logic rst_pull_low,
  output logic bat_sel,
  output logic bat_low
);
  import por_pkg::*;

  localparam int unsigned TERM = stretch_ticks(TB_HZ, STRETCH_MS);
  localparam int unsigned CW   = $clog2(TERM + 1);

  logic          fail_sync;
  logic          fail_pending;
  logic          stretching;
  logic [CW-1:0] count;

  por_fail_sync u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .fail_async   (pwr_fail),
    .fail_sync    (fail_sync),
    .fail_pending (fail_pending)
  );

  por_stretch_ctr #(.TERM(TERM), .CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fail_sync  (fail_sync),
    .stretching (stretching),
    .count      (count)
  );

  por_batt_sel u_batt (
    .bat1_ok     (bat1_ok),
    .bat2_ok     (bat2_ok),
    .bat2_higher (bat2_higher),
    .bat_sel     (bat_sel),
    .bat_low     (bat_low)
  );

  // Raw flag gives the immediate pull; the synchronizer and counter hold it.
  assign rst_pull_low = pwr_fail | fail_pending | stretching | !rst_n;

  AST_PULL_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> rst_pull_low) else $error("fail not pulled"); // R1
  AST_HOLD_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> rst_pull_low) else $error("released mid count"); // R3
  AST_SYNC_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pull_low) |-> (!fail_sync && !$past(pwr_fail))) else $error("release with fail"); // R5

endmodule

// File: tb/por_stretch_top_tb.sv
module por_stretch_top_tb_top;

  localparam int unsigned HZ   = 32768;
  localparam int unsigned MS_A = 100;
  localparam int unsigned MS_B = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic bat1_ok = 1'b1, bat2_ok = 1'b1, bat2_higher = 1'b0;
  logic pull_a, sel_a, low_a;
  logic pull_b, sel_b, low_b;

  int unsigned errors = 0;
  int unsigned checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  por_stretch_top #(.TB_HZ(HZ), .STRETCH_MS(MS_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .bat1_ok(bat1_ok),
    .bat2_ok(bat2_ok), .bat2_higher(bat2_higher),
    .rst_pull_low(pull_a), .bat_sel(sel_a), .bat_low(low_a));

  por_stretch_top #(.TB_HZ(HZ), .STRETCH_MS(MS_B)) dut_clamp (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .bat1_ok(bat1_ok),
    .bat2_ok(bat2_ok), .bat2_higher(bat2_higher),
    .rst_pull_low(pull_b), .bat_sel(sel_b), .bat_low(low_b));

  // Stretch length from the requirement, written independently.
  function automatic int unsigned exp_term(input int unsigned hz, input int unsigned ms);
    int unsigned m;
    m = ms;
    if (m < 40) m = 40;
    if (m > 200) m = 200;
    return (hz * m) / 1000;
  endfunction

  localparam int unsigned TERM_A = 3276;
  localparam int unsigned TERM_B = 1310;

  // Edges since the last edge that saw the fail flag (or reset) high.
  int unsigned since = 0;
  always @(posedge clk) begin
    if (!rst_n || pwr_fail) since = 0;
    else if (since < 100000) since = since + 1;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pulls(input string req);
    chk(req, pull_a, pwr_fail | !rst_n | (since < TERM_A + 2));
    chk(req, pull_b, pwr_fail | !rst_n | (since < TERM_B + 2));
  endtask

  task automatic drive_batt_and_check();
    logic [2:0] v;
    v = 3'($urandom);
    bat1_ok = v[0]; bat2_ok = v[1]; bat2_higher = v[2];
    #1;
    chk("R6", sel_a, v[2]);
    chk("R6", sel_b, v[2]);
    chk("R7", low_a, !v[0] && !v[1]);
  endtask

  // One negedge step: check registered behaviour, then drive new fail value.
  task automatic step(input logic fail_next);
    @(negedge clk);
    chk_pulls("R3");
    pwr_fail = fail_next;
    #1;
    if (fail_next) chk("R1", pull_a, 1'b1);
  endtask

  task automatic quiet(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    chk("R4", (exp_term(HZ, MS_A) == TERM_A), 1'b1);
    chk("R4", (exp_term(HZ, MS_B) == TERM_B), 1'b1);
    chk("R4", (exp_term(HZ, 500) == 6553), 1'b1);
    repeat (3) @(negedge clk);
    chk("R2", pull_a, 1'b1);
    chk("R2", pull_b, 1'b1);
    rst_n = 1'b1;
    // R2/R3: release after reset
    quiet(TERM_A + 10);
    chk("R3", pull_a, 1'b0);
    // R1 immediate pull with raw flag from idle
    @(negedge clk);
    pwr_fail = 1'b1;
    #1;
    chk("R1", pull_a, 1'b1);
    chk("R1", pull_b, 1'b1);
    step(1'b1); step(1'b0);
    quiet(TERM_A + 8);
    // R5: single-edge pulse exactly at the edge where release is due
    step(1'b1); step(1'b0);
    quiet(TERM_A);
    step(1'b1); step(1'b0);
    quiet(TERM_A + 6);
    // R5: pulse exactly where the clamped instance would release
    step(1'b1); step(1'b0);
    quiet(TERM_B);
    step(1'b1); step(1'b0);
    quiet(TERM_A + 6);
    // Random fail pulses and battery patterns
    for (int t = 0; t < 40000; t++) begin
      logic f;
      f = ($urandom % 900) == 0;
      if (f) begin
        for (int k = 0; k < int'($urandom % 4); k++) step(1'b1);
      end
      step(f);
      if ((t % 7) == 0) drive_batt_and_check();
    end
    quiet(TERM_A + 6);
    chk("R3", pull_a, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule